// File: doc/BRIEF.md
# Deferred interrupt-enable controller

This block holds the interrupts-enabled flag of a 12-bit minicomputer core. It watches instructions as they retire and decodes the three processor I/O opcodes that govern interrupts. Two of these opcodes switch interrupts off at once. One of them also asks the PC logic to skip the next instruction when interrupts were on. The third opcode turns interrupts on, but the new state takes hold only after one more instruction has retired. The Start key forces the flag off.

Requests come from two devices: the keyboard (input ready) and the teleprinter (output ready). The block gates these requests at instruction boundaries. When the committed flag is set and a request is present as an instruction retires, it raises a one-cycle take strobe for the vectoring logic. Taking an interrupt clears the flag. The ION display bit shows the committed flag, never the pending one. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `ion_ctrl`

## Requirements
- R1: After reset, ion_led_o, skip_req_o and irq_take_o are 0. The pending enable is clear, so a later retire of an ordinary instruction leaves ion_led_o at 0.
- R2: Retiring opcode 12'o6001 with interrupts off leaves ion_led_o at 0 after that retire. ion_led_o becomes 1 after the next retire.
- R3: skip_req_o is 1 in exactly the cycle where retire_i is 1, retire_op_i equals 12'o6000 and ion_led_o is 1. It is 0 in every other cycle.
- R4: Retiring 12'o6000 turns interrupts off at that clock edge and cancels any pending enable.
- R5: Retiring 12'o6002 turns interrupts off at that clock edge and cancels any pending enable.
- R6: A cycle with start_key_i high clears both the flag and the pending enable. It takes priority over every opcode in that same cycle.
- R7: irq_take_o is 1 exactly when retire_i is 1, ion_led_o is 1, at least one bit of irq_req_i is 1 (bit 0 keyboard input ready, bit 1 teleprinter output ready), and the retiring opcode is neither 12'o6000 nor 12'o6002.
- R8: Taking an interrupt clears the flag and the pending enable at that clock edge.
- R9: In cycles with retire_i low and start_key_i low, the flag and the pending enable do not change, and irq_take_o stays 0 whatever the request lines do.
- R10: Only full 12-bit matches decode. Any other opcode, such as 12'o6003, counts as an ordinary instruction: it commits a pending enable and does not block a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One-cycle strobe: an instruction retires this cycle |
| retire_op_i | input | 12 | Opcode of the retiring instruction |
| start_key_i | input | 1 | Start key press pulse |
| irq_req_i | input | NREQ | Request lines: bit 0 keyboard ready, bit 1 teleprinter ready |
| skip_req_o | output | 1 | Skip-next request to the PC logic |
| ion_led_o | output | 1 | Committed interrupts-enabled flag for display |
| irq_take_o | output | 1 | Interrupt taken at this instruction boundary |

## Verification
Several functions can land on the same retire edge. The most important case pairs the skip-and-disable opcode with a pending request while interrupts are on: the skip must win and the take must be suppressed. A second case pairs the instruction that would commit a pending enable with either a Start key press or a disabling opcode. The bench forces both pairings as directed cases and then creates them again many times through weighted random opcode and request choices. Each cycle is judged against a bench model that applies the priorities of R4 to R8.

// File: rtl/ion_pkg.sv
`timescale 1ns/1ps
package ion_pkg;
  localparam int OPW = 12;
  // Opcodes whose behaviour is decoded (octal)
  localparam logic [OPW-1:0] OP_SKIP_OFF = 12'o6000;
  localparam logic [OPW-1:0] OP_ENA_LATE = 12'o6001;
  localparam logic [OPW-1:0] OP_DIS_NOW  = 12'o6002;

  typedef struct packed {
    logic skip_off;
    logic ena_late;
    logic dis_now;
  } iot_dec_t;
endpackage

// File: rtl/ion_rst_sync.sv
`timescale 1ns/1ps
module ion_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ion_iot_decode.sv
`timescale 1ns/1ps
module ion_iot_decode
  import ion_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           retire_i,
  input  logic [OPW-1:0] op_i,
  output iot_dec_t       dec_o
);
  // Full-width compares only; other opcodes act as ordinary instructions.
  always_comb begin
    dec_o.skip_off = retire_i && (op_i == OP_SKIP_OFF);
    dec_o.ena_late = retire_i && (op_i == OP_ENA_LATE);
    dec_o.dis_now  = retire_i && (op_i == OP_DIS_NOW);
  end

  // R10: at most one decoded function per retire, none without retire
  a_r10_dec_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_o.skip_off, dec_o.ena_late, dec_o.dis_now}));
  a_r10_dec_needs_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_i) |-> ({dec_o.skip_off, dec_o.ena_late, dec_o.dis_now} == 3'b000));
endmodule

// File: rtl/ion_req_gate.sv
`timescale 1ns/1ps
module ion_req_gate
  import ion_pkg::*;
#(
  parameter int NREQ = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_i,
  input  iot_dec_t        dec_i,
  input  logic            ion_i,
  input  logic [NREQ-1:0] req_i,
  output logic            skip_o,
  output logic            take_o
);
  logic any_req;
  logic kills_ion;

  assign any_req   = |req_i;
  assign kills_ion = dec_i.skip_off || dec_i.dis_now;

  always_comb begin
    skip_o = dec_i.skip_off && ion_i;
    take_o = retire_i && ion_i && any_req && !kills_ion;
  end

  // R7: a take only happens at a boundary with the flag committed
  a_r7_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (retire_i && ion_i));
  // R3: skip and take never coincide
  a_r3_skip_excludes_take: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> (ion_i && !take_o));
endmodule

// File: rtl/ion_flag_reg.sv
`timescale 1ns/1ps
module ion_flag_reg
  import ion_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     retire_i,
  input  logic     start_i,
  input  iot_dec_t dec_i,
  input  logic     take_i,
  output logic     ion_o
);
  logic ion_q, ion_d;
  logic pend_q, pend_d;
  logic upd_en;

  assign upd_en = start_i || retire_i;

  always_comb begin
    ion_d  = ion_q;
    pend_d = pend_q;
    if (start_i) begin
      ion_d  = 1'b0;
      pend_d = 1'b0;
    end else if (retire_i) begin
      if (dec_i.skip_off || dec_i.dis_now || take_i) begin
        ion_d  = 1'b0;
        pend_d = 1'b0;
      end else begin
        ion_d  = ion_q || pend_q;
        pend_d = dec_i.ena_late;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ion_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (upd_en) begin
      ion_q  <= ion_d;
      pend_q <= pend_d;
    end
  end

  assign ion_o = ion_q;

  a_r2_enable_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i.ena_late && !pend_q && !ion_q && !start_i) |=> (!ion_q && pend_q));
  a_r4_skip_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i.skip_off && !start_i) |=> (!ion_q && !pend_q));
  a_r5_dis_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i.dis_now && !start_i) |=> (!ion_q && !pend_q));
  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!ion_q && !pend_q));
  a_r8_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (!ion_q && !pend_q));
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_i && !start_i) |=> ($stable(ion_q) && $stable(pend_q)));
endmodule

// File: rtl/ion_ctrl.sv
`timescale 1ns/1ps
module ion_ctrl
  import ion_pkg::*;
#(
  parameter int NREQ        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_i,
  input  logic [OPW-1:0]  retire_op_i,
  input  logic            start_key_i,
  input  logic [NREQ-1:0] irq_req_i,
  output logic            skip_req_o,
  output logic            ion_led_o,
  output logic            irq_take_o
);
  logic     rst_n_s;
  iot_dec_t dec;
  logic     ion;
  logic     take;
  logic     skip;

  ion_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  ion_iot_decode u_dec (
    .clk(clk), .rst_n(rst_n_s), .retire_i(retire_i),
    .op_i(retire_op_i), .dec_o(dec)
  );

  ion_req_gate #(.NREQ(NREQ)) u_gate (
    .clk(clk), .rst_n(rst_n_s), .retire_i(retire_i), .dec_i(dec),
    .ion_i(ion), .req_i(irq_req_i), .skip_o(skip), .take_o(take)
  );

  ion_flag_reg u_flag (
    .clk(clk), .rst_n(rst_n_s), .retire_i(retire_i), .start_i(start_key_i),
    .dec_i(dec), .take_i(take), .ion_o(ion)
  );

  assign skip_req_o = skip;
  assign ion_led_o  = ion;
  assign irq_take_o = take;

  // R1: outputs quiet while the synchronised reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    (!rst_n_s) |-> (!skip_req_o && !irq_take_o));
endmodule

// File: tb/sim_ion_ctrl.sv
`timescale 1ns/1ps
module sim_ion_ctrl;
  localparam int NREQ = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        retire;
  logic [11:0] op;
  logic        start;
  logic [NREQ-1:0] req;
  logic        skip, ion_led, take;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  bit m_ion = 0;
  bit m_pend = 0;

  always #10 clk = ~clk;

  ion_ctrl #(.NREQ(NREQ), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .retire_op_i(op),
    .start_key_i(start), .irq_req_i(req),
    .skip_req_o(skip), .ion_led_o(ion_led), .irq_take_o(take)
  );

  function automatic bit disables(input logic [11:0] o);
    return (o == 12'o6000) || (o == 12'o6002);
  endfunction

  function automatic bit exp_skip(input bit r, input logic [11:0] o, input bit fl);
    return r && (o == 12'o6000) && fl;
  endfunction

  function automatic bit exp_take(input bit r, input logic [11:0] o, input bit fl,
                                  input logic [NREQ-1:0] rq);
    return r && fl && (|rq) && !disables(o);
  endfunction

  task automatic chk(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive one cycle (caller sits just after a falling edge), check, advance model.
  task automatic step(input bit r, input logic [11:0] o, input bit s,
                      input logic [NREQ-1:0] rq, input string tag);
    bit t;
    retire = r; op = o; start = s; req = rq;
    #2;
    t = exp_take(r, o, m_ion, rq);
    chk(tag, "ion_led", ion_led, m_ion);
    chk(tag, "skip", skip, exp_skip(r, o, m_ion));
    chk(tag, "take", take, t);
    if (s) begin
      m_ion = 0; m_pend = 0;
    end else if (r) begin
      if (disables(o) || t) begin
        m_ion = 0; m_pend = 0;
      end else begin
        m_ion = m_ion | m_pend;
        m_pend = (o == 12'o6001);
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  localparam logic [11:0] NOP = 12'o7000;

  task automatic enable_now();
    step(1, 12'o6001, 0, 2'b00, "R2");
    step(1, NOP, 0, 2'b00, "R2");
  endtask

  initial begin
    rst_n = 1'b0; retire = 0; op = '0; start = 0; req = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #2;
    chk("R1", "ion_led after reset", ion_led, 0);
    chk("R1", "skip after reset", skip, 0);
    chk("R1", "take after reset", take, 0);
    @(negedge clk);
    step(1, NOP, 0, 2'b11, "R1");
    step(1, NOP, 0, 2'b11, "R1");

    // R2 deferred enable
    step(1, 12'o6001, 0, 2'b00, "R2");
    step(1, NOP, 0, 2'b00, "R2");   // ion still 0 here
    step(0, NOP, 0, 2'b00, "R2");   // ion now 1
    chk("R2", "ion rises after next retire", ion_led, 1);

    // R7 take, R8 clears
    step(1, NOP, 0, 2'b01, "R7");
    step(1, NOP, 0, 2'b00, "R8");
    chk("R8", "ion after take", ion_led, 0);

    // R3 skip with ion on, conflict with pending request (take suppressed)
    enable_now();
    step(1, 12'o6000, 0, 2'b10, "R3");
    step(1, 12'o6000, 0, 2'b00, "R4"); // ion off: no skip
    // R4 cancels pending
    step(1, 12'o6001, 0, 2'b00, "R4");
    step(1, 12'o6000, 0, 2'b00, "R4");
    step(1, NOP, 0, 2'b00, "R4");
    step(1, NOP, 0, 2'b00, "R4");
    chk("R4", "pending cancelled by skip op", ion_led, 0);

    // R5
    enable_now();
    step(1, 12'o6002, 0, 2'b01, "R5");
    step(1, 12'o6001, 0, 2'b00, "R5");
    step(1, 12'o6002, 0, 2'b00, "R5");
    step(1, NOP, 0, 2'b00, "R5");
    chk("R5", "pending cancelled by disable op", ion_led, 0);

    // R6 start priority
    enable_now();
    step(0, NOP, 1, 2'b00, "R6");
    step(1, 12'o6001, 1, 2'b00, "R6");
    step(1, NOP, 0, 2'b00, "R6");
    step(0, NOP, 0, 2'b00, "R6");
    chk("R6", "start overrides enable", ion_led, 0);
    step(1, 12'o6001, 0, 2'b00, "R6");
    step(1, NOP, 1, 2'b00, "R6");
    step(0, NOP, 0, 2'b00, "R6");
    chk("R6", "start blocks commit", ion_led, 0);

    // R9 idle cycles
    step(1, 12'o6001, 0, 2'b00, "R9");
    repeat (4) step(0, NOP, 0, 2'b11, "R9");
    chk("R9", "pending not committed without retire", ion_led, 0);
    step(1, NOP, 0, 2'b00, "R9");
    repeat (4) step(0, 12'o6002, 0, 2'b11, "R9");
    chk("R9", "ion held while idle", ion_led, 1);

    // R10 near-miss opcodes are ordinary
    step(1, 12'o6003, 0, 2'b10, "R10");
    step(1, 12'o6001, 0, 2'b00, "R10");
    step(1, 12'o4002, 0, 2'b00, "R10");
    step(1, 12'o6004, 0, 2'b01, "R10");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] o;
      case ($urandom % 7)
        0: o = 12'o6000;
        1: o = 12'o6001;
        2: o = 12'o6002;
        3: o = 12'o6003;
        4: o = 12'o6001;
        default: o = 12'($urandom);
      endcase
      step(($urandom % 4) != 0, o, ($urandom % 40) == 0,
           NREQ'($urandom % 4 == 0 ? $urandom : 0), "R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule